// File: doc/BRIEF.md
# Transceiver Bring-Up Configuration Sequencer

This block brings a line-interface transceiver into service after power-up without help from software. A single start pulse runs a fixed, ordered program of accesses over a simple synchronous register bus. The program:

- pulses a software reset and waits for the part to recover;
- reads back and checks the identification code;
- programs the clock setup, waiting for the clock system to settle when the 1.544 MHz master clock is selected;
- writes zero to every ordinary register location;
- sets up the framer and the line unit;
- as its very last action, marks initialization complete in both framer mode registers.

The configuration values come from input ports and are captured at the start pulse. The block reports busy while the program runs, done when it has finished cleanly, and an identification error when the part does not answer with the expected code. After an error it stops and issues no further bus access.

The bus carries one access at a time. Each access has these signals:

- an address;
- write data;
- a write or read strobe;
- read data;
- a ready input.

A strobe, together with its address and data, is held until the target raises ready. The access completes on the first clock edge at which the strobe and ready are both high.

Top module: `xcvr_init_seq`

## Requirements
- R1: After reset, busy_o, done_o and id_err_o are low and neither bus strobe is asserted. At most one of the three status outputs is high at any time.
- R2: A start_i pulse seen while the block is not busy begins the program, and busy_o is high from the next edge. A start_i pulse seen while busy is ignored: the program is not restarted and the access list is unchanged.
- R3: The first two accesses are writes to address 0xF0: data 0x01, then 0x00. The ID read strobe rises exactly RST_RECOV_CYC+3 clock edges after the edge that accepted the second write.
- R4: The third access is a read of address 0xF1. If the data read differs from EXP_ID, id_err_o rises, busy_o falls, and no further strobe is issued. Otherwise the program continues.
- R5: The fourth access writes the captured clock word to address 0xF2. When bit 0 of that word is 1 (1.544 MHz master clock), the next strobe rises SETTLE_CYC+3 edges after the edge that accepted the clock write, where SETTLE_CYC = ceil(300 ns / clock period). When bit 0 is 0, it rises 3 edges after.
- R6: Every address from 0x00 to 0xEF is then written with 0x00, in ascending order. The global window 0xF0 to 0xFF is skipped, and the only writes ever made into that window go to 0xF0 and 0xF2.
- R7: Next come writes to the transmit framer mode register (0x10) and then the receive framer mode register (0x11). Each takes bit 0 = E1 select, bit 1 = framer enable = 1 and bit 2 = init-done = 0. These are followed by tx_ctl_i to 0x12 and rx_ctl_i to 0x13.
- R8: Next come the line-unit writes: mode to 0x20 (bit 0 = E1 select), build-out to 0x21 (lbo_i zero-extended), and transmit enable 0x01 to 0x22.
- R9: The last two writes repeat the 0x10 and 0x11 values with bit 2 (init-done) set. done_o then rises and busy_o falls, and no access follows.
- R10: Strobes never overlap. A strobe that is not yet accepted keeps its kind, address and data on the next cycle. Each access has exactly one strobe assertion.
- R11: All configuration inputs are captured at the accepted start pulse. Changes to them during the program have no effect on the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| line_e1_i | input | 1 | 1 = E1 line mode, 0 = T1/J1 |
| clk_cfg_i | input | DATA_W | Clock configuration word; bit 0 selects the 1.544 MHz master clock |
| tx_ctl_i | input | DATA_W | Transmit framer control value |
| rx_ctl_i | input | DATA_W | Receive framer control value |
| lbo_i | input | LBO_W | Line build-out code |
| busy_o | output | 1 | Program running |
| done_o | output | 1 | Program completed |
| id_err_o | output | 1 | Identification mismatch, program halted |
| bus_addr_o | output | ADDR_W | Access address |
| bus_wdata_o | output | DATA_W | Write data |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdata_i | input | DATA_W | Read data |
| bus_rdy_i | input | 1 | Access accepted on an edge where a strobe and this input are high |

## Verification
The bench records each accepted access against the number of the edge that accepted it, because the completing edge is the one at which a strobe and ready are both high. It records each strobe rise against the edge that raised it. Outputs and strobes are sampled on the falling edge, and ready is chosen there for the coming edge. The two waits are therefore checked as exact differences of edge numbers: a strobe rises RST_RECOV_CYC+3 edges after the reset-clear write, and SETTLE_CYC+3 or 3 edges after the clock write. Ready is randomized so that these distances are tested against a bus that stalls. The status outputs are checked once busy_o has dropped, and a further idle stretch confirms that no strobe follows done or an identification error.

// File: rtl/xcvr_init_pkg.sv
package xcvr_init_pkg;
  typedef enum logic [2:0] {OP_WR, OP_RD, OP_WAIT, OP_CLEAR, OP_END} op_e;
  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_ACC, ST_WAIT, ST_DONE, ST_ERR} st_e;

  // register addresses
  localparam int A_SWRST  = 'hF0;
  localparam int A_DEVID  = 'hF1;
  localparam int A_CLKCFG = 'hF2;
  localparam int A_TXMODE = 'h10;
  localparam int A_RXMODE = 'h11;
  localparam int A_TXCTL  = 'h12;
  localparam int A_RXCTL  = 'h13;
  localparam int A_LMODE  = 'h20;
  localparam int A_LBO    = 'h21;
  localparam int A_LTXEN  = 'h22;

  // bit positions
  localparam int B_E1   = 0;
  localparam int B_FEN  = 1;
  localparam int B_INIT = 2;
  localparam int B_MCLK = 0;

  localparam int N_STEPS = 17;
endpackage

// File: rtl/xcvr_init_bus.sv
module xcvr_init_bus #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o       <= 1'b0;
      rdata_o     <= '0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
      bus_wr_o    <= 1'b0;
      bus_rd_o    <= 1'b0;
    end else begin
      ack_o <= 1'b0;
      if (bus_wr_o || bus_rd_o) begin
        if (bus_rdy_i) begin
          bus_wr_o <= 1'b0;
          bus_rd_o <= 1'b0;
          ack_o    <= 1'b1;
          if (bus_rd_o) rdata_o <= bus_rdata_i;
        end
      end else if (req_i) begin
        bus_wr_o    <= we_i;
        bus_rd_o    <= !we_i;
        bus_addr_o  <= addr_i;
        bus_wdata_o <= we_i ? wdata_i : '0;
      end
    end
  end
endmodule

// File: rtl/xcvr_init_timer.sv
module xcvr_init_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             fin_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= count_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // last waiting cycle
  assign fin_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/xcvr_init_steps.sv
module xcvr_init_steps
  import xcvr_init_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int LBO_W    = 3,
  parameter int STEP_W   = 5,
  parameter int WAIT_W   = 5,
  parameter int RST_WAIT = 20,
  parameter int CLK_WAIT = 30
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [ADDR_W-1:0] clr_addr_i,
  input  logic              e1_i,
  input  logic [DATA_W-1:0] clk_cfg_i,
  input  logic [DATA_W-1:0] tx_ctl_i,
  input  logic [DATA_W-1:0] rx_ctl_i,
  input  logic [LBO_W-1:0]  lbo_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [WAIT_W-1:0] wait_o
);
  logic [DATA_W-1:0] mode_w, lmode_w;

  always_comb begin
    mode_w          = '0;
    mode_w[B_E1]    = e1_i;
    mode_w[B_FEN]   = 1'b1;
    lmode_w         = '0;
    lmode_w[B_E1]   = e1_i;
  end

  always_comb begin
    op_o   = OP_WR;
    addr_o = '0;
    data_o = '0;
    wait_o = '0;
    case (step_i)
      STEP_W'(0):  begin addr_o = ADDR_W'(A_SWRST);  data_o = DATA_W'(1); end
      STEP_W'(1):  begin addr_o = ADDR_W'(A_SWRST);  end
      STEP_W'(2):  begin op_o = OP_WAIT; wait_o = WAIT_W'(RST_WAIT); end
      STEP_W'(3):  begin op_o = OP_RD; addr_o = ADDR_W'(A_DEVID); end
      STEP_W'(4):  begin addr_o = ADDR_W'(A_CLKCFG); data_o = clk_cfg_i; end
      STEP_W'(5):  begin
        op_o   = OP_WAIT;
        wait_o = clk_cfg_i[B_MCLK] ? WAIT_W'(CLK_WAIT) : '0;
      end
      STEP_W'(6):  begin op_o = OP_CLEAR; addr_o = clr_addr_i; end
      STEP_W'(7):  begin addr_o = ADDR_W'(A_TXMODE); data_o = mode_w; end
      STEP_W'(8):  begin addr_o = ADDR_W'(A_RXMODE); data_o = mode_w; end
      STEP_W'(9):  begin addr_o = ADDR_W'(A_TXCTL);  data_o = tx_ctl_i; end
      STEP_W'(10): begin addr_o = ADDR_W'(A_RXCTL);  data_o = rx_ctl_i; end
      STEP_W'(11): begin addr_o = ADDR_W'(A_LMODE);  data_o = lmode_w; end
      STEP_W'(12): begin addr_o = ADDR_W'(A_LBO);    data_o = DATA_W'(lbo_i); end
      STEP_W'(13): begin addr_o = ADDR_W'(A_LTXEN);  data_o = DATA_W'(1); end
      STEP_W'(14): begin
        addr_o = ADDR_W'(A_TXMODE);
        data_o = mode_w | (DATA_W'(1) << B_INIT);
      end
      STEP_W'(15): begin
        addr_o = ADDR_W'(A_RXMODE);
        data_o = mode_w | (DATA_W'(1) << B_INIT);
      end
      default:     op_o = OP_END;
    endcase
  end
endmodule

// File: rtl/xcvr_init_seq.sv
module xcvr_init_seq
  import xcvr_init_pkg::*;
#(
  parameter int              ADDR_W        = 8,
  parameter int              DATA_W        = 8,
  parameter int              LBO_W         = 3,
  parameter int              GLB_BASE      = 'hF0,
  parameter int              GLB_SIZE      = 16,
  parameter int              CLK_PERIOD_PS = 10000,
  parameter int              SETTLE_PS     = 300000,
  parameter int              RST_RECOV_CYC = 20,
  parameter logic [DATA_W-1:0] EXP_ID      = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              line_e1_i,
  input  logic [DATA_W-1:0] clk_cfg_i,
  input  logic [DATA_W-1:0] tx_ctl_i,
  input  logic [DATA_W-1:0] rx_ctl_i,
  input  logic [LBO_W-1:0]  lbo_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              id_err_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_rdy_i
);
  localparam int SETTLE_CYC = (SETTLE_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int WAIT_MAX   = (RST_RECOV_CYC > SETTLE_CYC) ? RST_RECOV_CYC : SETTLE_CYC;
  localparam int WAIT_W     = $clog2(WAIT_MAX + 1);
  localparam int STEP_W     = $clog2(N_STEPS);
  localparam int CLR_W      = ADDR_W + 1;

  st_e               st_q;
  logic [STEP_W-1:0] step_q;
  logic [CLR_W-1:0]  clr_q;
  logic              e1_q;
  logic [DATA_W-1:0] clk_cfg_q, tx_ctl_q, rx_ctl_q;
  logic [LBO_W-1:0]  lbo_q;

  op_e               op;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [WAIT_W-1:0] op_wait;
  logic              req, ack, tmr_load, tmr_fin, in_win, clr_end, start_ok;
  logic [DATA_W-1:0] rdata;

  xcvr_init_steps #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LBO_W(LBO_W), .STEP_W(STEP_W),
    .WAIT_W(WAIT_W), .RST_WAIT(RST_RECOV_CYC), .CLK_WAIT(SETTLE_CYC)
  ) u_steps (
    .step_i(step_q), .clr_addr_i(clr_q[ADDR_W-1:0]), .e1_i(e1_q),
    .clk_cfg_i(clk_cfg_q), .tx_ctl_i(tx_ctl_q), .rx_ctl_i(rx_ctl_q),
    .lbo_i(lbo_q), .op_o(op), .addr_o(op_addr), .data_o(op_data),
    .wait_o(op_wait)
  );

  xcvr_init_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .we_i(op != OP_RD),
    .addr_i(op_addr), .wdata_i(op_data), .ack_o(ack), .rdata_o(rdata),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_wr_o(bus_wr_o),
    .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i), .bus_rdy_i(bus_rdy_i)
  );

  xcvr_init_timer #(.CNT_W(WAIT_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .count_i(op_wait),
    .fin_o(tmr_fin)
  );

  generate
    if (GLB_SIZE > 0) begin : g_win
      assign in_win = (clr_q >= CLR_W'(GLB_BASE)) && (clr_q < CLR_W'(GLB_BASE + GLB_SIZE));
    end else begin : g_nowin
      assign in_win = 1'b0;
    end
  endgenerate

  assign clr_end  = clr_q[ADDR_W];
  assign busy_o   = (st_q == ST_RUN) || (st_q == ST_ACC) || (st_q == ST_WAIT);
  assign done_o   = (st_q == ST_DONE);
  assign id_err_o = (st_q == ST_ERR);
  assign start_ok = start_i && !busy_o;

  always_comb begin
    req      = 1'b0;
    tmr_load = 1'b0;
    if (st_q == ST_RUN) begin
      case (op)
        OP_WR, OP_RD: req = 1'b1;
        OP_CLEAR:     req = !clr_end && !in_win;
        OP_WAIT:      tmr_load = (op_wait != '0);
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      step_q    <= '0;
      clr_q     <= '0;
      e1_q      <= 1'b0;
      clk_cfg_q <= '0;
      tx_ctl_q  <= '0;
      rx_ctl_q  <= '0;
      lbo_q     <= '0;
    end else if (start_ok) begin
      st_q      <= ST_RUN;
      step_q    <= '0;
      clr_q     <= '0;
      e1_q      <= line_e1_i;
      clk_cfg_q <= clk_cfg_i;
      tx_ctl_q  <= tx_ctl_i;
      rx_ctl_q  <= rx_ctl_i;
      lbo_q     <= lbo_i;
    end else begin
      case (st_q)
        ST_RUN: begin
          case (op)
            OP_WR, OP_RD: st_q <= ST_ACC;
            OP_WAIT: begin
              if (op_wait == '0) step_q <= step_q + 1'b1;
              else               st_q   <= ST_WAIT;
            end
            OP_CLEAR: begin
              if (clr_end)     step_q <= step_q + 1'b1;
              else if (in_win) clr_q  <= clr_q + 1'b1;
              else             st_q   <= ST_ACC;
            end
            default: st_q <= ST_DONE;
          endcase
        end
        ST_ACC: begin
          if (ack) begin
            if (op == OP_RD && rdata != EXP_ID) begin
              st_q <= ST_ERR;
            end else begin
              st_q <= ST_RUN;
              if (op == OP_CLEAR) clr_q  <= clr_q + 1'b1;
              else                step_q <= step_q + 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (tmr_fin) begin
            st_q   <= ST_RUN;
            step_q <= step_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/xcvr_init_chk.sv
module xcvr_init_chk
  import xcvr_init_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int GLB_BASE = 'hF0,
  parameter int GLB_SIZE = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              done_o,
  input logic              id_err_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_wr_o,
  input logic              bus_rd_o,
  input logic              bus_rdy_i
);
  assert_status_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, id_err_o}));

  assert_err_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_err_o |-> !bus_wr_o && !bus_rd_o);

  assert_window_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_o && int'(bus_addr_o) >= GLB_BASE && int'(bus_addr_o) < GLB_BASE + GLB_SIZE)
      |-> (int'(bus_addr_o) == A_SWRST || int'(bus_addr_o) == A_CLKCFG));

  assert_init_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (int'(bus_addr_o) == A_RXMODE) && bus_wdata_o[B_INIT]);

  assert_one_access_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bus_wr_o || bus_rd_o) && !bus_rdy_i)
      |=> (bus_wr_o == $past(bus_wr_o)) && (bus_rd_o == $past(bus_rd_o))
          && $stable(bus_addr_o) && $stable(bus_wdata_o));
endmodule

bind xcvr_init_seq xcvr_init_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GLB_BASE(GLB_BASE), .GLB_SIZE(GLB_SIZE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .id_err_o(id_err_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
  .bus_wr_o(bus_wr_o), .bus_rd_o(bus_rd_o), .bus_rdy_i(bus_rdy_i)
);

// File: tb/tb_xcvr_init_seq.sv
module tb_xcvr_init_seq;
  localparam int CLK_NS = 10;
  localparam int RREC   = 20;
  localparam int SETTLE = 30;   // 300 ns / 10 ns
  localparam logic [7:0] DEV_ID = 8'hA5;
  localparam int LOGN = 300;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic       start_i = 1'b0, line_e1_i = 1'b0;
  logic [7:0] clk_cfg_i = '0, tx_ctl_i = '0, rx_ctl_i = '0;
  logic [2:0] lbo_i = '0;
  logic       busy_o, done_o, id_err_o, bus_wr_o, bus_rd_o;
  logic [7:0] bus_addr_o, bus_wdata_o;
  logic [7:0] bus_rdata_i = '0;
  logic       bus_rdy_i = 1'b0;

  xcvr_init_seq #(.CLK_PERIOD_PS(CLK_NS*1000), .RST_RECOV_CYC(RREC), .EXP_ID(DEV_ID)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .line_e1_i(line_e1_i),
    .clk_cfg_i(clk_cfg_i), .tx_ctl_i(tx_ctl_i), .rx_ctl_i(rx_ctl_i), .lbo_i(lbo_i),
    .busy_o(busy_o), .done_o(done_o), .id_err_o(id_err_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_wr_o(bus_wr_o),
    .bus_rd_o(bus_rd_o), .bus_rdata_i(bus_rdata_i), .bus_rdy_i(bus_rdy_i)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, rdy_pct = 75;
  logic [7:0] id_model = DEV_ID;
  logic       act_we [LOGN];
  logic [7:0] act_a  [LOGN];
  logic [7:0] act_d  [LOGN];
  int         acc_e  [LOGN];
  int         rise_e [LOGN];
  int         n_acc = 0, n_rise = 0;
  logic       exp_we [LOGN];
  logic [7:0] exp_a  [LOGN];
  logic [7:0] exp_d  [LOGN];
  int         n_exp = 0;
  logic       stb, prev_stb = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // bus target model, sampled and driven on the falling edge
  always @(negedge clk) begin
    stb = bus_wr_o | bus_rd_o;
    if (stb && !prev_stb && n_rise < LOGN) begin
      rise_e[n_rise] = cyc;
      n_rise++;
    end
    prev_stb    = stb;
    bus_rdy_i   = ($urandom % 100) < rdy_pct;
    bus_rdata_i = (bus_rd_o && bus_addr_o == 8'hF1) ? id_model : 8'h00;
    if (stb && bus_rdy_i && n_acc < LOGN) begin
      act_we[n_acc] = bus_wr_o;
      act_a[n_acc]  = bus_addr_o;
      act_d[n_acc]  = bus_wdata_o;
      acc_e[n_acc]  = cyc + 1;
      n_acc++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic we, input logic [7:0] a, input logic [7:0] d);
    exp_we[n_exp] = we; exp_a[n_exp] = a; exp_d[n_exp] = d; n_exp++;
  endtask

  function automatic string tag_of(input int i);
    if (i < 2)   return "R3";
    if (i == 2)  return "R4";
    if (i == 3)  return "R5";
    if (i < 244) return "R6";
    if (i < 248) return "R7";
    if (i < 251) return "R8";
    return "R9";
  endfunction

  task automatic build_exp(input logic e1, input logic [7:0] ck, input logic [7:0] txc,
                           input logic [7:0] rxc, input logic [2:0] lbo, input bit id_ok);
    logic [7:0] mode;
    n_exp = 0;
    push(1, 8'hF0, 8'h01);
    push(1, 8'hF0, 8'h00);
    push(0, 8'hF1, 8'h00);
    if (!id_ok) return;
    push(1, 8'hF2, ck);
    for (int a = 0; a < 'hF0; a++) push(1, 8'(a), 8'h00);
    mode = {6'b0, 1'b1, e1};
    push(1, 8'h10, mode);
    push(1, 8'h11, mode);
    push(1, 8'h12, txc);
    push(1, 8'h13, rxc);
    push(1, 8'h20, {7'b0, e1});
    push(1, 8'h21, {5'b0, lbo});
    push(1, 8'h22, 8'h01);
    push(1, 8'h10, mode | 8'h04);
    push(1, 8'h11, mode | 8'h04);
  endtask

  task automatic run(input logic e1, input logic [7:0] ck, input logic [7:0] txc,
                     input logic [7:0] rxc, input logic [2:0] lbo, input logic [7:0] id,
                     input bit mid_start, input bit chg_cfg);
    bit id_ok;
    int n_end;
    id_ok = (id == DEV_ID);
    id_model = id;
    line_e1_i = e1; clk_cfg_i = ck; tx_ctl_i = txc; rx_ctl_i = rxc; lbo_i = lbo;
    @(negedge clk);
    n_acc = 0; n_rise = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2", "busy after start", int'(busy_o), 1);
    if (chg_cfg) begin  // R11: late changes must not reach the bus
      line_e1_i = ~e1; clk_cfg_i = ~ck; tx_ctl_i = ~txc; rx_ctl_i = ~rxc; lbo_i = ~lbo;
    end
    if (mid_start) begin
      repeat (60) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    build_exp(e1, ck, txc, rxc, lbo, id_ok);
    chk(n_acc == n_exp, id_ok ? "R9" : "R4", "access count", n_acc, n_exp);
    for (int i = 0; i < n_exp && i < n_acc; i++) begin
      chk(act_we[i] == exp_we[i] && act_a[i] == exp_a[i] && (!exp_we[i] || act_d[i] == exp_d[i]),
          tag_of(i), $sformatf("access %0d addr/data", i),
          {act_we[i], act_a[i], act_d[i]}, {exp_we[i], exp_a[i], exp_d[i]});
    end
    chk(n_rise == n_acc, "R10", "strobe rises vs accesses", n_rise, n_acc);
    if (n_rise > 2 && n_acc > 1)
      chk(rise_e[2] - acc_e[1] == RREC + 3, "R3", "recovery gap", rise_e[2] - acc_e[1], RREC + 3);
    if (id_ok && n_rise > 4 && n_acc > 3)
      chk(rise_e[4] - acc_e[3] == (ck[0] ? SETTLE : 0) + 3, "R5", "settle gap",
          rise_e[4] - acc_e[3], (ck[0] ? SETTLE : 0) + 3);
    if (id_ok) chk(done_o && !id_err_o, "R9", "done status", {done_o, id_err_o}, 2'b10);
    else       chk(id_err_o && !done_o, "R4", "error status", {done_o, id_err_o}, 2'b01);
    n_end = n_acc;
    repeat (30) @(negedge clk);
    chk(n_acc == n_end, id_ok ? "R9" : "R4", "no access after end", n_acc, n_end);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357));
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !id_err_o, "R1", "status in reset", {busy_o, done_o, id_err_o}, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(!bus_wr_o && !bus_rd_o && n_acc == 0, "R1", "no strobe after reset",
        {bus_wr_o, bus_rd_o}, 0);
    chk(!busy_o && !done_o && !id_err_o, "R1", "idle status", {busy_o, done_o, id_err_o}, 0);
    // directed: T1, 1.544 MHz clock
    run(1'b0, 8'h01, 8'h3C, 8'hC3, 3'd5, DEV_ID, 0, 0);
    // E1, other clock, start while busy (R2)
    run(1'b1, 8'h40, 8'h81, 8'h18, 3'd2, DEV_ID, 1, 0);
    // slow target
    rdy_pct = 15;
    run(1'b1, 8'h03, 8'hFF, 8'h00, 3'd7, DEV_ID, 0, 0);
    rdy_pct = 75;
    // ID mismatch (R4), then recovery with good ID
    run(1'b0, 8'h01, 8'h11, 8'h22, 3'd1, 8'h5A, 0, 0);
    run(1'b0, 8'h00, 8'h11, 8'h22, 3'd1, DEV_ID, 0, 0);
    // inputs change during run (R11)
    run(1'b1, 8'h81, 8'h66, 8'h99, 3'd3, DEV_ID, 0, 1);
    // random configurations
    for (int k = 0; k < 4; k++) begin
      rdy_pct = 30 + ($urandom % 70);
      run(1'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom),
          DEV_ID, 1'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule